// File: doc/BRIEF.md
# Interrupt Controller Configuration Register File

This block is the byte-addressed register front end of a multi-source interrupt controller. It holds the per-source enable bits and the 4-bit priority fields. It also holds the fast-interrupt selection word, the software-interrupt trigger and the non-maskable-interrupt (NMI) enable and mode controls. It exports the enables, priorities and fast-interrupt selection as flat vectors to the arbitration logic. Writes to the software-interrupt register produce a one-cycle pulse toward the core.

The per-source pending flags live in the arbitration logic. This block reads them through `pend_i`. A zero written to a pending flag's byte is forwarded as a one-cycle clear strobe on `pend_clr_o`. Every access carries a width flag. The fast-interrupt word accepts only 16-bit accesses, and every other register accepts only byte accesses. A mismatched access reads as all ones and writes nothing. Reads are combinational in the cycle `req_i` is high. Writes take effect at the next rising clock edge.

Address map (10-bit byte addresses): pending flags at `0x000 + n`, enable bytes at `0x100 + k`, software trigger at `0x180`, fast word at `0x190`, priorities at `0x200 + p`, and the NMI group at `0x280` (status), `0x281` (enable), `0x282` (clear) and `0x283` (control).

Top module: `intc_cfg_regs`

## Requirements
- R1: After reset, `en_o`, `prio_o`, `fast_en_o`, `fast_vec_o`, `nmi_en_o`, `nmi_mode_o`, `swi_o` and `pend_clr_o` are all zero.
- R2: The fast word at 0x190 is accessed only with `wide_i`=1, and every other register only with `wide_i`=0. A read of the wrong width returns 16'hFFFF. A write of the wrong width changes no register and produces no pulse.
- R3: The fast word keeps the vector in bits 7:0 (`fast_vec_o`) and the enable in bit 15 (`fast_en_o`). Bits 14:8 are dropped on write and read as zero.
- R4: Priority byte 0x200+p keeps only bits 3:0, which drive `prio_o[4p+3:4p]`. Bits 7:4 read back as zero.
- R5: Enable byte 0x100+k bit b drives `en_o[8k+b]` and reads back unchanged.
- R6: A byte write to 0x180 with bit 0 set raises `swi_o` for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse. Reads of 0x180 return 0.
- R7: A byte write to 0x281 ORs bits 2:0 (bit 0 NMI, bit 1 low-voltage detect, bit 2 oscillation stop) into `nmi_en_o`. Bits can be set but never cleared, and bits 7:3 are dropped.
- R8: Bit 3 of 0x283 (`nmi_mode_o`) is written only while `nmi_en_o[0]` is 0. Once that bit is 1, writes leave the mode unchanged. Other bits of 0x283 read as zero.
- R9: The NMI status (0x280) and NMI clear (0x282) registers always read 0.
- R10: Reads of unmapped addresses return 16'hFFFF, and writes to them change no output.
- R11: A byte read of 0x000+n returns `pend_i[n]` in bit 0. A byte write of 8'h00 there pulses `pend_clr_o[n]` alone for one cycle. A nonzero write pulses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| rdata_o | output | 16 | Read data, valid while a read is requested |
| pend_i | input | N_SRC | Pending flags from the arbitration logic |
| pend_clr_o | output | N_SRC | One-cycle pending-clear strobes |
| en_o | output | N_SRC | Per-source enables |
| prio_o | output | 4*N_PRIO | Packed 4-bit priorities |
| fast_en_o | output | 1 | Fast-interrupt enable |
| fast_vec_o | output | 8 | Fast-interrupt source number |
| swi_o | output | 1 | Software-interrupt pulse |
| nmi_en_o | output | 3 | NMI, low-voltage, oscillation-stop enables |
| nmi_mode_o | output | 1 | NMI mode bit |

## Verification
The bench sweeps every byte value through every enable and priority register. A priority store that kept its upper nibble would read back wrong, and so would an enable bit wired to the wrong source. It pairs each register with the wrong access width. A design that ignored the width would return real data instead of all ones, or would let a byte write change the fast word. It runs the NMI registers through an order that first sets only the low-voltage bit, then locks the mode. A design that locked on any enable bit would refuse that later mode write, and one that stored NMI enables plainly would clear them. Pulse checks look at the cycle after the write and the cycle after that. A level instead of a pulse would show up there, and so would a clear strobe sent to the wrong source.

// File: rtl/intc_cfg_pkg.sv
package intc_cfg_pkg;
  localparam int unsigned ADDR_W = 10;

  localparam logic [ADDR_W-1:0] SWI_ADDR  = 10'h180;
  localparam logic [ADDR_W-1:0] FAST_ADDR = 10'h190;
  localparam logic [ADDR_W-1:0] NMI_BASE  = 10'h280;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_PEND,
    RG_EN,
    RG_SWI,
    RG_FAST,
    RG_PRIO,
    RG_NSTAT,
    RG_NEN,
    RG_NCLR,
    RG_NCTL
  } region_e;
endpackage

// File: rtl/intc_cfg_dec.sv
module intc_cfg_dec
  import intc_cfg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output region_e           region_o,
  output logic [7:0]        idx_o,
  output logic              width_ok_o
);
  localparam int unsigned N_EN = N_SRC / 8;

  logic [1:0] page;
  logic [7:0] off;
  assign page = addr_i[9:8];
  assign off  = addr_i[7:0];

  always_comb begin
    region_o = RG_NONE;
    idx_o    = off;
    unique case (page)
      2'd0: if (32'(off) < N_SRC) region_o = RG_PEND;
      2'd1: begin
        if (32'(off) < N_EN)           region_o = RG_EN;
        else if (off == SWI_ADDR[7:0])  region_o = RG_SWI;
        else if (off == FAST_ADDR[7:0]) region_o = RG_FAST;
      end
      2'd2: begin
        if (32'(off) < N_PRIO) region_o = RG_PRIO;
        else if (off[7:2] == NMI_BASE[7:2]) begin
          unique case (off[1:0])
            2'd0: region_o = RG_NSTAT;
            2'd1: region_o = RG_NEN;
            2'd2: region_o = RG_NCLR;
            default: region_o = RG_NCTL;
          endcase
        end
      end
      default: region_o = RG_NONE;
    endcase
  end

  // only the fast word is 16 bits wide
  assign width_ok_o = (region_o == RG_FAST) ? wide_i : !wide_i;
endmodule

// File: rtl/intc_cfg_store.sv
module intc_cfg_store
  import intc_cfg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  region_e             region_i,
  input  logic [7:0]          idx_i,
  input  logic [15:0]         wdata_i,
  output logic [N_SRC-1:0]    en_o,
  output logic [4*N_PRIO-1:0] prio_o,
  output logic                fast_en_o,
  output logic [7:0]          fast_vec_o,
  output logic [15:0]         rdata_o
);
  localparam int unsigned N_EN  = N_SRC / 8;
  localparam int unsigned EN_IW = (N_EN > 1) ? $clog2(N_EN) : 1;
  localparam int unsigned PR_IW = (N_PRIO > 1) ? $clog2(N_PRIO) : 1;

  logic [7:0] en_q   [N_EN];
  logic [3:0] prio_q [N_PRIO];

  for (genvar k = 0; k < N_EN; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[k] <= '0;
      else if (wr_i && region_i == RG_EN && 32'(idx_i) == k) en_q[k] <= wdata_i[7:0];
    end
    assign en_o[8*k +: 8] = en_q[k];
  end

  for (genvar p = 0; p < N_PRIO; p++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[p] <= '0;
      else if (wr_i && region_i == RG_PRIO && 32'(idx_i) == p) prio_q[p] <= wdata_i[3:0];
    end
    assign prio_o[4*p +: 4] = prio_q[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_en_o  <= 1'b0;
      fast_vec_o <= '0;
    end else if (wr_i && region_i == RG_FAST) begin
      fast_en_o  <= wdata_i[15];
      fast_vec_o <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (region_i)
      RG_EN:   rdata_o[7:0] = en_q[idx_i[EN_IW-1:0]];
      RG_PRIO: rdata_o[3:0] = prio_q[idx_i[PR_IW-1:0]];
      RG_FAST: rdata_o      = {fast_en_o, 7'b0, fast_vec_o};
      default: rdata_o      = '0;
    endcase
  end
endmodule

// File: rtl/intc_cfg_nmi.sv
module intc_cfg_nmi
  import intc_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  region_e     region_i,
  input  logic [7:0]  wdata_i,
  output logic [2:0]  nmi_en_o,
  output logic        nmi_mode_o,
  output logic [15:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_en_o   <= '0;
      nmi_mode_o <= 1'b0;
    end else if (wr_i) begin
      // enables are set-only
      if (region_i == RG_NEN) nmi_en_o <= nmi_en_o | wdata_i[2:0];
      // mode frozen once the NMI itself is enabled
      if (region_i == RG_NCTL && !nmi_en_o[0]) nmi_mode_o <= wdata_i[3];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (region_i)
      RG_NEN:  rdata_o[2:0] = nmi_en_o;
      RG_NCTL: rdata_o[3]   = nmi_mode_o;
      default: rdata_o      = '0;
    endcase
  end
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_cfg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                wide_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  input  logic [N_SRC-1:0]    pend_i,
  output logic [N_SRC-1:0]    pend_clr_o,
  output logic [N_SRC-1:0]    en_o,
  output logic [4*N_PRIO-1:0] prio_o,
  output logic                fast_en_o,
  output logic [7:0]          fast_vec_o,
  output logic                swi_o,
  output logic [2:0]          nmi_en_o,
  output logic                nmi_mode_o
);
  localparam int unsigned SRC_IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  region_e     region;
  logic [7:0]  idx;
  logic        width_ok;
  logic        wr;
  logic [15:0] store_rd;
  logic [15:0] nmi_rd;

  intc_cfg_dec #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) u_dec (
    .addr_i     (addr_i),
    .wide_i     (wide_i),
    .region_o   (region),
    .idx_o      (idx),
    .width_ok_o (width_ok)
  );

  assign wr = req_i && we_i && width_ok;

  intc_cfg_store #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .region_i   (region),
    .idx_i      (idx),
    .wdata_i    (wdata_i),
    .en_o       (en_o),
    .prio_o     (prio_o),
    .fast_en_o  (fast_en_o),
    .fast_vec_o (fast_vec_o),
    .rdata_o    (store_rd)
  );

  intc_cfg_nmi u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .region_i   (region),
    .wdata_i    (wdata_i[7:0]),
    .nmi_en_o   (nmi_en_o),
    .nmi_mode_o (nmi_mode_o),
    .rdata_o    (nmi_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swi_o <= 1'b0;
    else         swi_o <= wr && region == RG_SWI && wdata_i[0];
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_clr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_clr_o[n] <= 1'b0;
      else pend_clr_o[n] <= wr && region == RG_PEND && 32'(idx) == n && wdata_i[7:0] == 8'h00;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (!width_ok) rdata_o = '1;
      else begin
        unique case (region)
          RG_PEND:                          rdata_o = {15'b0, pend_i[idx[SRC_IW-1:0]]};
          RG_EN, RG_PRIO, RG_FAST:          rdata_o = store_rd;
          RG_NSTAT, RG_NEN, RG_NCLR, RG_NCTL: rdata_o = nmi_rd;
          RG_SWI:                           rdata_o = '0;
          default:                          rdata_o = '1;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_cfg_chk.sv
module intc_cfg_chk
  import intc_cfg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic                wide_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [15:0]         wdata_i,
  input logic [15:0]         rdata_o,
  input logic [N_SRC-1:0]    pend_clr_o,
  input logic [4*N_PRIO-1:0] prio_o,
  input logic                fast_en_o,
  input logic [7:0]          fast_vec_o,
  input logic                swi_o,
  input logic [2:0]          nmi_en_o,
  input logic                nmi_mode_o
);
  logic prio_addr;
  assign prio_addr = addr_i[9:8] == 2'd2 && 32'(addr_i[7:0]) < N_PRIO;

  p_nmi_set_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_en_o & $past(nmi_en_o)) == $past(nmi_en_o));

  p_mode_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(nmi_en_o[0]) |-> $stable(nmi_mode_o));

  p_swi_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_o |-> $past(req_i && we_i && !wide_i && addr_i == SWI_ADDR && wdata_i[0]));

  p_clr_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o));

  p_fast_byte_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !wide_i && addr_i == FAST_ADDR) |-> rdata_o == 16'hFFFF);

  p_fast_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !wide_i && addr_i == FAST_ADDR) |=> ($stable(fast_vec_o) && $stable(fast_en_o)));

  p_prio_wide_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wide_i && prio_addr) |=> $stable(prio_o));
endmodule

bind intc_cfg_regs intc_cfg_chk #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .wide_i     (wide_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pend_clr_o (pend_clr_o),
  .prio_o     (prio_o),
  .fast_en_o  (fast_en_o),
  .fast_vec_o (fast_vec_o),
  .swi_o      (swi_o),
  .nmi_en_o   (nmi_en_o),
  .nmi_mode_o (nmi_mode_o)
);

// File: tb/intc_cfg_regs_tb.sv
`timescale 1ns/1ps
module intc_cfg_regs_tb;
  localparam int N_SRC  = 32;
  localparam int N_PRIO = 16;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, wide = 0;
  logic [9:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [N_SRC-1:0] pend = '0, pend_clr, en;
  logic [4*N_PRIO-1:0] prio;
  logic fast_en, swi, nmi_mode;
  logic [7:0] fast_vec;
  logic [2:0] nmi_en;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  intc_cfg_regs #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pend_i(pend),
    .pend_clr_o(pend_clr), .en_o(en), .prio_o(prio), .fast_en_o(fast_en),
    .fast_vec_o(fast_vec), .swi_o(swi), .nmi_en_o(nmi_en), .nmi_mode_o(nmi_mode)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic w, logic [15:0] d);
    @(negedge clk);
    req = 1; we = 1; wide = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wide = 0;
  endtask

  task automatic rd(logic [9:0] a, logic w, output logic [15:0] d);
    @(negedge clk);
    req = 1; we = 0; wide = w; addr = a;
    #1 d = rdata;
    req = 0; wide = 0;
  endtask

  function automatic logic [63:0] snap();
    return {en, prio[31:0]} ^ {42'b0, fast_en, fast_vec, nmi_en, nmi_mode, swi, pend_clr[7:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [63:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", en, 0);
    chk("R1 prio", prio, 0);
    chk("R1 fast", {fast_en, fast_vec}, 0);
    chk("R1 nmi", {nmi_en, nmi_mode}, 0);
    chk("R1 pulses", {swi, pend_clr}, 0);
    rst_ni = 1;
    @(negedge clk);
    rd(10'h281, 0, d); chk("R1 nmi_en read", d, 0);

    // R5 enable sweep
    for (int k = 0; k < N_SRC/8; k++) begin
      for (int v = 0; v < 256; v++) begin
        wr(10'h100 + 10'(k), 0, 16'(v));
        chk("R5 en_o", en[8*k +: 8], 64'(v));
        rd(10'h100 + 10'(k), 0, d);
        chk("R5 readback", d, 64'(v));
      end
    end

    // R4 priority sweep
    for (int p = 0; p < N_PRIO; p++) begin
      for (int v = 0; v < 256; v++) begin
        wr(10'h200 + 10'(p), 0, 16'(v) | 16'hAB00);
        chk("R4 prio_o", prio[4*p +: 4], 64'(v % 16));
        rd(10'h200 + 10'(p), 0, d);
        chk("R4 readback", d, 64'(v % 16));
      end
    end

    // R3 fast word
    wr(10'h190, 1, 16'hFFFF);
    chk("R3 outs", {fast_en, fast_vec}, 9'h1FF);
    rd(10'h190, 1, d); chk("R3 read", d, 16'h80FF);
    wr(10'h190, 1, 16'h7F5A);
    chk("R3 outs2", {fast_en, fast_vec}, 9'h05A);
    rd(10'h190, 1, d); chk("R3 read2", d, 16'h005A);

    // R2 width checks
    rd(10'h190, 0, d); chk("R2 byte read fast", d, 16'hFFFF);
    wr(10'h190, 0, 16'h8033);
    chk("R2 byte write fast", {fast_en, fast_vec}, 9'h05A);
    wr(10'h203, 0, 16'h0009);
    rd(10'h203, 1, d); chk("R2 wide read prio", d, 16'hFFFF);
    wr(10'h203, 1, 16'h0004);
    chk("R2 wide write prio", prio[15:12], 4'h9);
    wr(10'h180, 1, 16'h0001);
    chk("R2 wide swi", swi, 0);
    wr(10'h101, 1, 16'h0000);
    chk("R2 wide en", en[15:8], 8'hFF);

    // R6 software trigger
    wr(10'h180, 0, 16'h0001);
    chk("R6 pulse", swi, 1);
    @(negedge clk); chk("R6 pulse end", swi, 0);
    wr(10'h180, 0, 16'h00FE);
    chk("R6 bit0 clear", swi, 0);
    rd(10'h180, 0, d); chk("R6 read", d, 0);

    // R8 mode while unlocked
    wr(10'h283, 0, 16'h00FF);
    chk("R8 mode set", nmi_mode, 1);
    rd(10'h283, 0, d); chk("R8 read", d, 16'h0008);
    wr(10'h283, 0, 16'h0000);
    chk("R8 mode clr", nmi_mode, 0);
    // R7 set-only enables; low-voltage bit alone does not lock mode
    wr(10'h281, 0, 16'h0002);
    chk("R7 lvd", nmi_en, 3'b010);
    wr(10'h283, 0, 16'h0008);
    chk("R8 still writable", nmi_mode, 1);
    wr(10'h283, 0, 16'h0000);
    wr(10'h281, 0, 16'h0001);
    chk("R7 or", nmi_en, 3'b011);
    wr(10'h283, 0, 16'h0008);
    chk("R8 locked", nmi_mode, 0);
    wr(10'h281, 0, 16'h0000);
    chk("R7 no clear", nmi_en, 3'b011);
    wr(10'h281, 0, 16'h00FC);
    chk("R7 all", nmi_en, 3'b111);
    rd(10'h281, 0, d); chk("R7 read", d, 16'h0007);

    // R9 status/clear
    wr(10'h280, 0, 16'h00FF);
    wr(10'h282, 0, 16'h00FF);
    rd(10'h280, 0, d); chk("R9 status", d, 0);
    rd(10'h282, 0, d); chk("R9 clear", d, 0);
    chk("R9 nmi kept", nmi_en, 3'b111);

    // R10 unmapped
    rd(10'h300, 0, d); chk("R10 page3", d, 16'hFFFF);
    rd(10'h191, 0, d); chk("R10 odd fast", d, 16'hFFFF);
    rd(10'h0FF, 0, d); chk("R10 past sources", d, 16'hFFFF);
    rd(10'h284, 0, d); chk("R10 past nmi", d, 16'hFFFF);
    s = snap();
    wr(10'h300, 0, 16'h0000);
    wr(10'h120, 0, 16'h00FF);
    wr(10'h0FF, 0, 16'h0000);
    chk("R10 write no effect", snap(), s);
    chk("R10 en", en, {N_SRC{1'b1}});

    // R11 pending access
    pend = 32'hA5C3_1E69;
    for (int n = 0; n < N_SRC; n++) begin
      rd(10'(n), 0, d);
      chk("R11 read", d, 64'(pend[n]));
    end
    wr(10'h005, 0, 16'h0000);
    chk("R11 clr pulse", pend_clr, 32'h0000_0020);
    @(negedge clk); chk("R11 clr end", pend_clr, 0);
    wr(10'h01F, 0, 16'h0000);
    chk("R11 clr top", pend_clr, 32'h8000_0000);
    wr(10'h005, 0, 16'h0001);
    chk("R11 nonzero", pend_clr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule